// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse Width Modulator

This block generates four independent pulse-width-modulated outputs from one input clock. Each channel has its own clock divider. The divider stretches every step of the channel's period counter to (prescale+1) input cycles, and the output stays high for the first `duty` steps of each `period`. Software sets the channels through a small word-addressed register bus.

Each channel exposes three registers: control (run bit and divider), duty and period. A single global run bit sits above all four channels. A channel drives pulses only when both its own run bit and the global bit are set.

Duty, period and divider values written while a channel is running are staged. The channel picks them up at its next period boundary, so a pulse is never cut short or stretched halfway through a period. When a channel is stopped, it clears its counters. The next start therefore always begins at the top of a period.

Top module: `pwm_bank`

## Requirements
- R1: After reset, every register reads zero and every output is low.
- R2: A control register holds the run bit at bit 0 and the divider value in bits 15:2. Duty and period each hold 16 bits at bits 15:0. Bits with no storage read zero.
- R3: Channel n's registers start at byte address n*0x10, with control at +0x0, duty at +0x4 and period at +0x8. The global run bit is bit 0 of the word at 0x3C.
- R4: A write to any address outside the map changes no register, and a read from such an address returns zero.
- R5: An output can be high only while the global run bit and that channel's run bit are both 1. Clearing either bit forces the output low in the cycle after the write.
- R6: Once a channel starts, its output is high for duty*(prescale+1) input cycles and its period lasts period*(prescale+1) input cycles. The first high cycle is the cycle right after the starting write, provided duty is nonzero.
- R7: A duty value at or above the period value keeps the output high for the whole period. A duty value of zero keeps the output low.
- R8: Stopping a channel clears its divider and period counters. A later start begins a fresh period with the output high in its first cycle.
- R9: Duty, period or divider values written while a channel runs leave the current period unchanged and apply from the next period on.
- R10: The output of one channel stays low while only another channel is configured and running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register bus select |
| bus_enable | input | 1 | Register bus access phase; a write commits when select, enable and write are all high |
| bus_write | input | 1 | 1 for a write access, 0 for a read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, decoded combinationally from bus_addr |
| pwm_out | output | 4 | One pulse output per channel |

## Verification
The bench builds the block with its default parameters: four channels, a 14-bit divider, 16-bit duty and period, and the global run register at 0x3C. All-ones writes reach the full width of every field, which proves the bit placement and the zero padding without running long waveforms. The waveform tests use dividers of 0 to 4 and periods of 1 to 8, so each period is short enough to count cycle by cycle. These small values still reach the corners that matter: a period of one step, duty equal to or above the period, zero duty, and a duty change staged partway through a period.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

   // Register selected inside a channel's address window
   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_DUTY = 2'd1,
      REG_PER  = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;

   localparam int        STRIDE_LSB = 4;     // 16-byte window per channel
   localparam int        PRE_LSB    = 2;     // divider field position in control word
   localparam int        BUS_W      = 32;
   localparam logic [3:0] SUB_CTRL  = 4'h0;
   localparam logic [3:0] SUB_DUTY  = 4'h4;
   localparam logic [3:0] SUB_PER   = 4'h8;

endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CH     = 4,
   parameter int PRE_W      = 14,
   parameter int CNT_W      = 16,
   parameter int ADDR_W     = 8,
   parameter int MASTER_OFS = 60
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_stb,
   input  logic [ADDR_W-1:0]                addr,
   input  logic [BUS_W-1:0]                 wdata,
   output logic [BUS_W-1:0]                 rdata,
   output logic                             master_en,
   output logic [NUM_CH-1:0]                ch_en,
   output logic [NUM_CH-1:0][PRE_W-1:0]     ch_pre,
   output logic [NUM_CH-1:0][CNT_W-1:0]     ch_duty,
   output logic [NUM_CH-1:0][CNT_W-1:0]     ch_per
);

   localparam int CI_W = ADDR_W - STRIDE_LSB;

   // elaboration-time parameter checks
   if (NUM_CH < 1) begin : g_bad_num
      $error("pwm_regfile: NUM_CH must be at least 1");
   end
   if (PRE_W + PRE_LSB > BUS_W || CNT_W > BUS_W || PRE_W < 1 || CNT_W < 1) begin : g_bad_width
      $error("pwm_regfile: field widths do not fit the bus word");
   end
   if (MASTER_OFS % 4 != 0 || MASTER_OFS >= (1 << ADDR_W)) begin : g_bad_master
      $error("pwm_regfile: global register offset misaligned or out of range");
   end
   if ((NUM_CH - 1) * 16 + 8 >= MASTER_OFS) begin : g_overlap
      $error("pwm_regfile: channel windows overlap the global register");
   end

   logic [CI_W-1:0]       ch_idx;
   logic [STRIDE_LSB-1:0] sub;
   logic                  ch_ok;
   logic                  hit_master;
   reg_sel_e              sel;
   logic                  unused_wdata;

   assign ch_idx       = addr[ADDR_W-1:STRIDE_LSB];
   assign sub          = addr[STRIDE_LSB-1:0];
   assign ch_ok        = int'(ch_idx) < NUM_CH;
   assign hit_master   = addr == ADDR_W'(MASTER_OFS);
   assign unused_wdata = ^wdata;

   always_comb begin
      sel = REG_NONE;
      if (ch_ok) begin
         case (sub)
            SUB_CTRL: sel = REG_CTRL;
            SUB_DUTY: sel = REG_DUTY;
            SUB_PER:  sel = REG_PER;
            default:  sel = REG_NONE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         master_en <= 1'b0;
         ch_en     <= '0;
         ch_pre    <= '0;
         ch_duty   <= '0;
         ch_per    <= '0;
      end else if (wr_stb) begin
         if (hit_master) master_en <= wdata[0];
         for (int i = 0; i < NUM_CH; i++) begin
            if (ch_idx == CI_W'(i)) begin
               case (sel)
                  REG_CTRL: begin
                     ch_en[i]  <= wdata[0];
                     ch_pre[i] <= wdata[PRE_LSB +: PRE_W];
                  end
                  REG_DUTY: ch_duty[i] <= wdata[CNT_W-1:0];
                  REG_PER:  ch_per[i]  <= wdata[CNT_W-1:0];
                  default: ;
               endcase
            end
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (hit_master) rdata[0] = master_en;
      for (int i = 0; i < NUM_CH; i++) begin
         if (ch_idx == CI_W'(i)) begin
            case (sel)
               REG_CTRL: begin
                  rdata[0]                 = ch_en[i];
                  rdata[PRE_LSB +: PRE_W]  = ch_pre[i];
               end
               REG_DUTY: rdata[CNT_W-1:0] = ch_duty[i];
               REG_PER:  rdata[CNT_W-1:0] = ch_per[i];
               default: ;
            endcase
         end
      end
   end

   // an access outside the map leaves every stored value untouched
   assert_unmapped_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && sel == REG_NONE && !hit_master) |=>
         ($stable(master_en) && $stable(ch_en) && $stable(ch_pre) &&
          $stable(ch_duty) && $stable(ch_per)));

   // the global run bit follows bit 0 of a write to its address
   assert_master_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && hit_master) |=> (master_en == $past(wdata[0])));

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
   parameter int PRE_W = 14,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PRE_W-1:0] cfg_pre,
   input  logic [CNT_W-1:0] cfg_duty,
   input  logic [CNT_W-1:0] cfg_per,
   output logic             wave
);

   logic             fresh_q;          // first running cycle: live values apply
   logic [PRE_W-1:0] pre_q, sh_pre;
   logic [CNT_W-1:0] cnt_q, sh_duty, sh_per;
   logic [PRE_W-1:0] eff_pre;
   logic [CNT_W-1:0] eff_duty, eff_per;
   logic [CNT_W:0]   cnt_nxt;
   logic             pre_wrap, per_last, per_wrap;

   assign eff_pre  = fresh_q ? cfg_pre  : sh_pre;
   assign eff_duty = fresh_q ? cfg_duty : sh_duty;
   assign eff_per  = fresh_q ? cfg_per  : sh_per;

   assign cnt_nxt  = {1'b0, cnt_q} + (CNT_W+1)'(1);
   assign pre_wrap = pre_q == eff_pre;
   assign per_last = cnt_nxt >= {1'b0, eff_per};   // a period of 0 acts as 1
   assign per_wrap = pre_wrap && per_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fresh_q <= 1'b1;
         pre_q   <= '0;
         cnt_q   <= '0;
         sh_pre  <= '0;
         sh_duty <= '0;
         sh_per  <= '0;
      end else if (!run) begin
         fresh_q <= 1'b1;
         pre_q   <= '0;
         cnt_q   <= '0;
      end else begin
         fresh_q <= 1'b0;
         if (fresh_q || per_wrap) begin
            sh_pre  <= cfg_pre;
            sh_duty <= cfg_duty;
            sh_per  <= cfg_per;
         end
         pre_q <= pre_wrap ? '0 : pre_q + 1'b1;
         if (pre_wrap) cnt_q <= per_last ? '0 : cnt_q + 1'b1;
      end
   end

   assign wave = run && (cnt_q < eff_duty);

   // a stopped channel holds both counters at zero
   assert_idle_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (pre_q == '0 && cnt_q == '0));

   // staged values stay put inside a running period
   assert_staged_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !fresh_q && !per_wrap) |=> ($stable(sh_duty) && $stable(sh_per) && $stable(sh_pre)));

   // the divider never passes the staged limit
   assert_pre_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !fresh_q) |-> (pre_q <= sh_pre));

   // period counter steps by exactly one on a divider wrap inside a period
   assert_step_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && pre_wrap && !per_last) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CH     = 4,
   parameter int PRE_W      = 14,
   parameter int CNT_W      = 16,
   parameter int ADDR_W     = 8,
   parameter int MASTER_OFS = 60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_enable,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic [NUM_CH-1:0] pwm_out
);

   logic                         wr_stb;
   logic                         master_en;
   logic [NUM_CH-1:0]            ch_en;
   logic [NUM_CH-1:0][PRE_W-1:0] ch_pre;
   logic [NUM_CH-1:0][CNT_W-1:0] ch_duty;
   logic [NUM_CH-1:0][CNT_W-1:0] ch_per;

   assign wr_stb = bus_sel && bus_enable && bus_write;

   pwm_regfile #(
      .NUM_CH    (NUM_CH),
      .PRE_W     (PRE_W),
      .CNT_W     (CNT_W),
      .ADDR_W    (ADDR_W),
      .MASTER_OFS(MASTER_OFS)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb   (wr_stb),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .rdata    (bus_rdata),
      .master_en(master_en),
      .ch_en    (ch_en),
      .ch_pre   (ch_pre),
      .ch_duty  (ch_duty),
      .ch_per   (ch_per)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      pwm_chan #(
         .PRE_W(PRE_W),
         .CNT_W(CNT_W)
      ) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .run     (master_en && ch_en[g]),
         .cfg_pre (ch_pre[g]),
         .cfg_duty(ch_duty[g]),
         .cfg_per (ch_per[g]),
         .wave    (pwm_out[g])
      );

      // an output high implies both run bits set
      assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
         pwm_out[g] |-> (master_en && ch_en[g]));
   end

endmodule

// File: tb/pwm_bank_bench.sv
`timescale 1ns/1ps
module pwm_bank_bench;

   typedef struct packed {
      int ch;
      int pre;
      int duty;
      int per;
      int exp_hi;
      int exp_len;
   } vec_t;

   // channel, divider, duty, period, expected high cycles, expected period cycles
   localparam vec_t VECS [7] = '{
      '{0, 0, 3, 8, 3, 8},
      '{1, 2, 2, 5, 6, 15},
      '{2, 1, 7, 7, 14, 14},
      '{3, 3, 1, 4, 4, 16},
      '{0, 0, 0, 6, 0, 6},
      '{2, 0, 9, 3, 3, 3},
      '{1, 4, 3, 1, 5, 5}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_enable = 1'b0;
   logic        bus_write = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  pwm_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pwm_bank u_pwm_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_enable(bus_enable),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pwm_out   (pwm_out)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_enable = 1'b1; bus_write = 1'b1;
      bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_enable = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_addr = a;
      #1;
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   // counts high cycles of one channel, and cycles where any other output is high
   task automatic measure(int ch, int n, output int hi, output int others);
      hi = 0;
      others = 0;
      for (int i = 0; i < n; i++) begin
         if (pwm_out[ch]) hi++;
         if ((pwm_out & ~(4'b0001 << ch)) != 4'b0000) others++;
         @(negedge clk);
      end
   endtask

   initial begin
      #(5ns * 20000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int hi, oth;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check("R1 outputs", 32'(pwm_out), 32'h0);
      for (int c = 0; c < 4; c++) begin
         rd(8'(c * 16), d);     check("R1 ctrl", d, 32'h0);
         rd(8'(c * 16 + 4), d); check("R1 duty", d, 32'h0);
         rd(8'(c * 16 + 8), d); check("R1 period", d, 32'h0);
      end
      rd(8'h3C, d); check("R1 global", d, 32'h0);

      // R2: field layout and zero padding
      wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, d); check("R2 ctrl all-ones", d, 32'h0000_FFFD);
      wr(8'h10, 32'h0000_0006); rd(8'h10, d); check("R2 ctrl divider only", d, 32'h0000_0004);
      wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, d); check("R2 duty width", d, 32'h0000_FFFF);
      wr(8'h18, 32'hABCD_1234); rd(8'h18, d); check("R2 period width", d, 32'h0000_1234);
      wr(8'h3C, 32'hFFFF_FFFF); rd(8'h3C, d); check("R2 global width", d, 32'h1);
      wr(8'h3C, 32'h0);
      wr(8'h10, 32'h0);

      // R3: address map, distinct value per channel
      for (int c = 0; c < 4; c++) wr(8'(c * 16 + 4), 32'h100 + 32'(c));
      for (int c = 0; c < 4; c++) begin
         rd(8'(c * 16 + 4), d); check("R3 channel window", d, 32'h100 + 32'(c));
      end
      wr(8'h3C, 32'h1); rd(8'h3C, d); check("R3 global at 0x3C", d, 32'h1);
      wr(8'h3C, 32'h0);

      // R4: unmapped addresses
      wr(8'h0C, 32'hFFFF_FFFF);
      wr(8'h02, 32'hFFFF_FFFF);
      wr(8'h3E, 32'hFFFF_FFFF);
      wr(8'h40, 32'hFFFF_FFFF);
      wr(8'h44, 32'hFFFF_FFFF);
      rd(8'h0C, d); check("R4 read 0x0C", d, 32'h0);
      rd(8'h40, d); check("R4 read 0x40", d, 32'h0);
      rd(8'h00, d); check("R4 ctrl0 untouched", d, 32'h0);
      rd(8'h3C, d); check("R4 global untouched", d, 32'h0);
      for (int c = 0; c < 4; c++) begin
         rd(8'(c * 16 + 4), d); check("R4 duty untouched", d, 32'h100 + 32'(c));
      end
      check("R4 outputs low", 32'(pwm_out), 32'h0);

      // R6 R7 R10: table of waveforms
      wr(8'h3C, 32'h1);
      foreach (VECS[k]) begin
         wr(8'(VECS[k].ch * 16 + 4), 32'(VECS[k].duty));
         wr(8'(VECS[k].ch * 16 + 8), 32'(VECS[k].per));
         wr(8'(VECS[k].ch * 16), 32'(VECS[k].pre << 2) | 32'h1);
         measure(VECS[k].ch, VECS[k].exp_len, hi, oth);
         check("R6 R7 high cycles in one period", 32'(hi), 32'(VECS[k].exp_hi));
         check("R10 other outputs", 32'(oth), 32'h0);
         check("R6 R7 first cycle of next period", 32'(pwm_out[VECS[k].ch]),
               32'(VECS[k].duty != 0));
         wr(8'(VECS[k].ch * 16), 32'(VECS[k].pre << 2));
         rd(8'(VECS[k].ch * 16), d);
         check("R2 divider kept on stop", d, 32'(VECS[k].pre << 2));
      end

      // R5: gating by the global bit
      wr(8'h3C, 32'h0);
      wr(8'h04, 32'd4); wr(8'h08, 32'd4); wr(8'h00, 32'h1);
      measure(0, 8, hi, oth);
      check("R5 low without global bit", 32'(hi), 32'h0);
      wr(8'h3C, 32'h1);
      measure(0, 8, hi, oth);
      check("R5 high with both bits", 32'(hi), 32'd8);
      wr(8'h3C, 32'h0);
      check("R5 low after global cleared", 32'(pwm_out[0]), 32'h0);
      wr(8'h3C, 32'h1);
      wr(8'h00, 32'h0);
      check("R5 low after channel cleared", 32'(pwm_out[0]), 32'h0);

      // R8: stop mid-period, restart from the top
      wr(8'h04, 32'd2); wr(8'h08, 32'd6); wr(8'h00, 32'h1);
      @(negedge clk); @(negedge clk); @(negedge clk);
      wr(8'h00, 32'h0);
      measure(0, 5, hi, oth);
      check("R8 low while stopped", 32'(hi), 32'h0);
      wr(8'h00, 32'h1);
      check("R8 high in first cycle", 32'(pwm_out[0]), 32'h1);
      measure(0, 6, hi, oth);
      check("R8 full period after restart", 32'(hi), 32'd2);
      wr(8'h00, 32'h0);

      // R9: duty change applies at the next period
      wr(8'h04, 32'd2); wr(8'h08, 32'd6); wr(8'h00, 32'h1);
      check("R9 start high", 32'(pwm_out[0]), 32'h1);
      wr(8'h04, 32'd5);          // lands two cycles into the period
      measure(0, 4, hi, oth);
      check("R9 current period keeps old duty", 32'(hi), 32'h0);
      measure(0, 6, hi, oth);
      check("R9 next period uses new duty", 32'(hi), 32'd5);
      wr(8'h00, 32'h0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule